// File: doc/BRIEF.md
# Dual Four-Bit Addressable Latch

This block holds two small banks of four storage bits each, called section a and section b. The two sections share one 2-bit bit-select, an active-low enable and an active-low master clear. Each section has its own data input. Every storage bit appears on its own output pin, so the block can work as a serial-to-parallel collector. It can also serve as a pair of 1-of-4 demultiplexers.

The master clear and the enable together pick one of four modes. In clear mode every bit is zeroed. In hold mode nothing changes. In write mode the selected bit of each section loads that section's data and the other bits keep their values. In demultiplex mode the selected bit of each section takes that section's data and all other bits are zeroed.

The model is fully synchronous. All inputs are sampled on the rising edge of `clk`. The storage register drives the outputs directly, so the outputs always equal the stored state. A separate power-on reset zeroes everything.

Top module: `dual_addr_latch`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `q` is 0 after that edge, whatever the mode, select and data inputs are.
- R2: Clear mode (`clr_n`=0, `en_n`=1) drives all eight bits of `q` to 0 at the next edge, for any `sel` and `din`.
- R3: Hold mode (`clr_n`=1, `en_n`=1) leaves `q` unchanged, and `sel` and `din` have no effect.
- R4: Write mode (`clr_n`=1, `en_n`=0) loads bit `sel` of each section with that section's data bit. The other three bits of each section keep their values.
- R5: Demultiplex mode (`clr_n`=0, `en_n`=0) sets bit `sel` of each section to that section's data bit and sets the other three bits to 0. With data high this gives a one-hot 1-of-4 decode in each section.
- R6: `sel` is a plain binary bit number with `sel[0]` as the least significant bit. `sel`=1 selects bit 1 and `sel`=3 selects bit 3.
- R7: Section a occupies `q[3:0]` and uses `din[0]`. Section b occupies `q[7:4]` and uses `din[1]`. Both sections use the same select and mode inputs, but each loads only its own data bit.
- R8: Outputs are registered. An input change takes effect on `q` only after the next rising edge of `clk`.
- R9: Storage always equals the outputs. After clear mode, hold mode keeps showing zeros. After demultiplex mode, hold mode keeps showing the demultiplexed pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous power-on reset, active high |
| clr_n | input | 1 | Master clear, active low; acts as one of the two mode inputs |
| en_n | input | 1 | Enable, active low; acts as one of the two mode inputs |
| sel | input | 2 | Bit select shared by both sections, binary |
| din | input | 2 | Data, bit 0 for section a, bit 1 for section b |
| q | output | 8 | Stored bits, section a in [3:0], section b in [7:4] |

## Verification
The assertions assume that the mode pins, `sel` and `din` are stable and known at every sampling edge. They also assume that a mode, once sampled, is held for a whole cycle. They do not assume that the select is held steady while the enable is active, because a clocked model makes that rule unnecessary. The stimulus changes every input only at the falling edge, which keeps it inside these assumptions. It also walks the select through all four codes in both write and demultiplex modes, so that both sections are exercised with equal and with opposite data.

// File: rtl/dal_pkg.sv
package dal_pkg;

    localparam int DAL_BITS     = 4;
    localparam int DAL_SECTIONS = 2;
    localparam int DAL_SEL_W    = $clog2(DAL_BITS);

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_WRITE = 2'd2,
        MODE_DEMUX = 2'd3
    } dal_mode_e;

    // One-hot mask of the selected bit
    function automatic logic [DAL_BITS-1:0] sel_mask(input logic [DAL_SEL_W-1:0] s);
        logic [DAL_BITS-1:0] m;
        m = '0;
        m[s] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dal_mode_dec.sv
module dal_mode_dec
    import dal_pkg::*;
(
    input  logic      clr_n,
    input  logic      en_n,
    output dal_mode_e mode
);

    always_comb begin
        unique case ({clr_n, en_n})
            2'b01:   mode = MODE_CLEAR;
            2'b11:   mode = MODE_HOLD;
            2'b10:   mode = MODE_WRITE;
            default: mode = MODE_DEMUX;
        endcase
    end

endmodule

// File: rtl/dal_section.sv
module dal_section
    import dal_pkg::*;
#(
    parameter int BITS  = DAL_BITS,
    localparam int SEL_W = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  dal_mode_e        mode,
    input  logic [SEL_W-1:0] sel,
    input  logic             din,
    output logic [BITS-1:0]  bits
);

    logic [BITS-1:0] mask;
    logic [BITS-1:0] nxt;

    always_comb begin
        mask = '0;
        mask[sel] = 1'b1;
    end

    always_comb begin
        unique case (mode)
            MODE_CLEAR: nxt = '0;
            MODE_HOLD:  nxt = bits;
            MODE_WRITE: nxt = (bits & ~mask) | (mask & {BITS{din}});
            default:    nxt = mask & {BITS{din}};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bits <= '0;
        else     bits <= nxt;
    end

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CLEAR) |=> (bits == '0));

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD) |=> $stable(bits));

    assert_write_loads_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WRITE) |=> (bits[$past(sel)] == $past(din)));

    assert_write_others_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WRITE) |=>
        (((bits ^ $past(bits)) & ~(BITS'(1) << $past(sel))) == '0));

    assert_demux_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DEMUX) |=>
        ($countones(bits) <= 1 && bits[$past(sel)] == $past(din)));

endmodule

// File: rtl/dual_addr_latch.sv
module dual_addr_latch
    import dal_pkg::*;
#(
    parameter int BITS     = DAL_BITS,
    parameter int SECTIONS = DAL_SECTIONS,
    localparam int SEL_W   = $clog2(BITS),
    localparam int Q_W     = BITS * SECTIONS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_n,
    input  logic                en_n,
    input  logic [SEL_W-1:0]    sel,
    input  logic [SECTIONS-1:0] din,
    output logic [Q_W-1:0]      q
);

    dal_mode_e mode;

    dal_mode_dec u_mode (
        .clr_n (clr_n),
        .en_n  (en_n),
        .mode  (mode)
    );

    for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
        dal_section #(.BITS(BITS)) u_sec (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .sel  (sel),
            .din  (din[s]),
            .bits (q[s*BITS +: BITS])
        );
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (q == '0));

endmodule

// File: tb/tb_dual_addr_latch.sv
module tb_dual_addr_latch;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    logic       clk = 1'b0;
    logic       rst, clr_n, en_n;
    logic [1:0] sel, din;
    logic [7:0] q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_addr_latch dut (
        .clk(clk), .rst(rst), .clr_n(clr_n), .en_n(en_n),
        .sel(sel), .din(din), .q(q)
    );

    // {rst, clr_n, en_n, sel[1:0], din[1:0], expected q[7:0]}
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 1'b1, 2'd0, 2'b00, 8'h00},
        {1'b0, 1'b1, 1'b0, 2'd0, 2'b01, 8'h01},
        {1'b0, 1'b1, 1'b0, 2'd1, 2'b11, 8'h23},
        {1'b0, 1'b1, 1'b0, 2'd3, 2'b10, 8'hA3},
        {1'b0, 1'b1, 1'b0, 2'd2, 2'b01, 8'hA7},
        {1'b0, 1'b1, 1'b1, 2'd0, 2'b00, 8'hA7},
        {1'b0, 1'b1, 1'b0, 2'd0, 2'b00, 8'hA6},
        {1'b0, 1'b1, 1'b1, 2'd3, 2'b11, 8'hA6},
        {1'b0, 1'b0, 1'b1, 2'd2, 2'b11, 8'h00},
        {1'b0, 1'b1, 1'b1, 2'd1, 2'b11, 8'h00},
        {1'b0, 1'b0, 1'b0, 2'd2, 2'b11, 8'h44},
        {1'b0, 1'b0, 1'b0, 2'd1, 2'b01, 8'h02},
        {1'b0, 1'b1, 1'b1, 2'd2, 2'b10, 8'h02},
        {1'b0, 1'b1, 1'b0, 2'd3, 2'b11, 8'h8A},
        {1'b0, 1'b0, 1'b0, 2'd3, 2'b10, 8'h80},
        {1'b0, 1'b0, 1'b0, 2'd0, 2'b11, 8'h11},
        {1'b0, 1'b1, 1'b0, 2'd3, 2'b11, 8'h99},
        {1'b1, 1'b1, 1'b0, 2'd2, 2'b11, 8'h00}
    };

    task automatic check(input string tag, input logic [7:0] exp);
        checks++;
        if (q !== exp) begin
            fails++;
            $display("FAIL %s: q=%h expected %h", tag, q, exp);
        end
    endtask

    task automatic drive(input logic r, input logic c, input logic e,
                         input logic [1:0] s, input logic [1:0] d);
        rst = r; clr_n = c; en_n = e; sel = s; din = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, q=%h expected completion", q);
        finish_run();
    end

    initial begin
        drive(1'b1, 1'b1, 1'b1, 2'd0, 2'b00);
        @(negedge clk);
        @(negedge clk);
        check("R1 reset state", 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            drive(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:10], VEC[i][9:8]);
            if (VEC[i][14])                         tag = "R1";
            else case ({VEC[i][13], VEC[i][12]})
                2'b01:   tag = "R2";
                2'b11:   tag = "R3";
                2'b10:   tag = "R4";
                default: tag = "R5";
            endcase
            @(negedge clk);
            check(tag, VEC[i][7:0]);
        end

        // R6: sel=1 selects bit 1, sel=3 selects bit 3 (demux, data high)
        drive(1'b0, 1'b0, 1'b0, 2'd1, 2'b11);
        @(negedge clk);
        check("R6 sel=1", 8'h22);
        drive(1'b0, 1'b0, 1'b0, 2'd3, 2'b11);
        @(negedge clk);
        check("R6 sel=3", 8'h88);

        // R7: opposite data per section, same select
        drive(1'b0, 1'b0, 1'b1, 2'd0, 2'b00);
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 2'd2, 2'b10);
        @(negedge clk);
        check("R7 b only", 8'h40);

        // R8: no change before the edge, change after it
        drive(1'b0, 1'b1, 1'b0, 2'd1, 2'b01);
        #(CLK_PERIOD/2 - 1);
        check("R8 before edge", 8'h40);
        @(negedge clk);
        check("R8 after edge", 8'h42);

        // R9: demux pattern persists through hold
        drive(1'b0, 1'b0, 1'b0, 2'd3, 2'b01);
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b1, 2'd0, 2'b11);
        @(negedge clk);
        @(negedge clk);
        check("R9 hold after demux", 8'h08);

        finish_run();
    end

endmodule